// File: doc/BRIEF.md
# Embedded Timer Unit with Fixed-Interval, Interval and Watchdog Timers

This block gives an embedded core three timers that all run off one external time-base value. A fixed-interval timer raises an event whenever a chosen bit of the time base changes. An interval timer counts down once for each cycle in which the time base moves, and it can reload itself after it expires. A watchdog, also driven by a chosen time-base bit, escalates in three steps. The first expiry arms it. The second raises an interrupt. The third records the configured reset kind in the status register and issues a one-cycle core, chip or system reset request.

Software uses a small register port. It writes a control register that holds the enables, the period codes, the auto-reload flag and the watchdog reset kind. It reads and clears a status register whose bits are cleared by writing 1. It writes the interval-timer reload value and reads the running count back. Each interrupt output is a status bit ANDed with its enable bit in the control register.

Top module: `emb_timer_unit`

## Requirements
- R1: After reset the control register, the status register and the interval count all read 0, and every interrupt and reset-request output is 0.
- R2: Register addresses are 0 for control, 1 for status, 2 for the interval reload/count, and 3, which reads 0 and ignores writes. Control keeps only bits 31:22 and reads 0 in bits 21:0.
- R3: With fixed-interval code c in control bits 25:24, a change of time-base bit 9+4c sets status bit 26. A change of any other tap bit does not set it.
- R4: irq_fixed equals status bit 26 ANDed with control bit 23.
- R5: Writing status clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R6: Writing N>1 to address 2 loads the count with N and starts it. Each cycle in which the time base differs from its value in the previous cycle lowers the count by one. The N-th such tick expires the timer and sets status bit 27. irq_interval equals status bit 27 ANDed with control bit 26. The count does not change without a tick or a write.
- R7: At expiry, with control bit 22 set, the count reloads N and the timer keeps running. With bit 22 clear, the count goes to 0 and the timer stops with no further expiry.
- R8: A reload value of 0 or 1 leaves the timer stopped. The count holds that value and the timer never expires.
- R9: With watchdog code c in control bits 31:30, a change of time-base bit 17+4c is a watchdog expiry. The first expiry sets status bit 31. The next sets status bit 30. Changes of other tap bits are ignored. irq_watchdog equals status bit 30 ANDed with control bit 27.
- R10: An expiry with status bits 31 and 30 both set copies control bits 29:28 into status bits 29:28. It then pulses for one cycle the reset request that the field names (0 none, 1 core, 2 chip, 3 system), with at most one request active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 interval, 3 none) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tbase | input | TB_W | Time-base value |
| irq_fixed | output | 1 | Fixed-interval interrupt |
| irq_interval | output | 1 | Interval-timer interrupt |
| irq_watchdog | output | 1 | Watchdog interrupt |
| rst_req_core | output | 1 | One-cycle core reset request |
| rst_req_chip | output | 1 | One-cycle chip reset request |
| rst_req_system | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that the time base is held steady while reset is applied and released. Otherwise the first edge after release would see a change against the cleared history register and report a tick. The stimulus therefore keeps the time base at zero through reset. After that it changes the time base by flipping one bit per cycle: bit 0 for interval ticks, and single tap bits for the fixed-interval and watchdog sweeps. This keeps each event tied to exactly one expected status change. Status clears are written only in cycles with no pending expiry, so the expected values do not depend on a same-edge set and clear.

// File: rtl/emb_timer_pkg.sv
package emb_timer_pkg;

  localparam int DATA_W = 32;
  localparam int NTAP   = 4;
  localparam int CODE_W = $clog2(NTAP);

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_PIT  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_CORE = 2'd1,
    RK_CHIP = 2'd2,
    RK_SYS  = 2'd3
  } rst_kind_e;

  // control field positions (lsb of each field)
  localparam int CB_WD_PER = 30;
  localparam int CB_WD_RST = 28;
  localparam int CB_WD_IE  = 27;
  localparam int CB_PIT_IE = 26;
  localparam int CB_FI_PER = 24;
  localparam int CB_FI_IE  = 23;
  localparam int CB_PIT_AR = 22;

  // status field positions
  localparam int SB_WD_ARM = 31;
  localparam int SB_WD_INT = 30;
  localparam int SB_RST    = 28;
  localparam int SB_PIT    = 27;
  localparam int SB_FI     = 26;

  localparam logic [DATA_W-1:0] CTRL_MASK = 32'hFFC0_0000;
  localparam logic [DATA_W-1:0] STAT_MASK = 32'hFC00_0000;

endpackage

// File: rtl/tb_tap_select.sv
module tb_tap_select
  import emb_timer_pkg::*;
#(
  parameter int N = NTAP,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  tap_now,
  input  logic [N-1:0]  tap_last,
  input  logic [SW-1:0] code,
  output logic          fire
);

  logic [N-1:0] toggled;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_tog
      assign toggled[gi] = tap_now[gi] ^ tap_last[gi];
    end
  endgenerate

  assign fire = toggled[code];

endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load_wr,
  input  logic [W-1:0] load_val,
  input  logic         auto_reload,
  output logic [W-1:0] count,
  output logic         expire
);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] rel_q, rel_d;
  logic         run_q, run_d;
  logic         upd_en;

  always_comb begin
    cnt_d  = cnt_q;
    rel_d  = rel_q;
    run_d  = run_q;
    expire = 1'b0;
    if (load_wr) begin
      rel_d = load_val;
      cnt_d = load_val;
      run_d = (load_val > W'(1));
    end else if (run_q && tick) begin
      if (cnt_q == W'(1)) begin
        expire = 1'b1;
        if (auto_reload && (rel_q > W'(1))) begin
          cnt_d = rel_q;
        end else begin
          cnt_d = '0;
          run_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q - W'(1);
      end
    end
  end

  assign upd_en = load_wr | (run_q & tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
      run_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
      run_q <= run_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/wdt_stage_ctrl.sv
module wdt_stage_ctrl
  import emb_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       st_armed,
  input  logic       st_int,
  input  logic [1:0] kind,
  output logic       set_armed,
  output logic       set_int,
  output logic       load_kind,
  output logic       req_core,
  output logic       req_chip,
  output logic       req_sys
);

  logic [2:0] req_q, req_d;

  always_comb begin
    set_armed = fire & ~st_armed;
    set_int   = fire & st_armed & ~st_int;
    load_kind = fire & st_armed & st_int;
    req_d     = 3'b000;
    if (load_kind) begin
      case (rst_kind_e'(kind))
        RK_CORE: req_d = 3'b001;
        RK_CHIP: req_d = 3'b010;
        RK_SYS:  req_d = 3'b100;
        default: req_d = 3'b000;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 3'b000;
    end else begin
      req_q <= req_d;
    end
  end

  assign req_core = req_q[0];
  assign req_chip = req_q[1];
  assign req_sys  = req_q[2];

endmodule

// File: rtl/emb_timer_unit.sv
module emb_timer_unit
  import emb_timer_pkg::*;
#(
  parameter int TB_W     = 32,
  parameter int FI_BASE  = 9,
  parameter int WD_BASE  = 17,
  parameter int TAP_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [TB_W-1:0]   tbase,
  output logic              irq_fixed,
  output logic              irq_interval,
  output logic              irq_watchdog,
  output logic              rst_req_core,
  output logic              rst_req_chip,
  output logic              rst_req_system
);

  localparam int FI_TOP = FI_BASE + (NTAP - 1) * TAP_STEP;
  localparam int WD_TOP = WD_BASE + (NTAP - 1) * TAP_STEP;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // time-base history
  logic [TB_W-1:0] tb_prev_q;
  logic            tb_tick;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) tb_prev_q <= '0;
    else             tb_prev_q <= tbase;
  end
  assign tb_tick = (tbase != tb_prev_q);

  // register decode
  logic ctrl_wr, stat_wr, pit_wr;
  assign ctrl_wr = reg_wr_en && (reg_addr == ADDR_CTRL);
  assign stat_wr = reg_wr_en && (reg_addr == ADDR_STAT);
  assign pit_wr  = reg_wr_en && (reg_addr == ADDR_PIT);

  // control register
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  assign ctrl_d = reg_wdata & CTRL_MASK;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  // tap extraction
  logic [NTAP-1:0] fi_now, fi_last, wd_now, wd_last;

  genvar gt;
  generate
    for (gt = 0; gt < NTAP; gt++) begin : g_taps
      assign fi_now[gt]  = tbase[FI_BASE + gt * TAP_STEP];
      assign fi_last[gt] = tb_prev_q[FI_BASE + gt * TAP_STEP];
      assign wd_now[gt]  = tbase[WD_BASE + gt * TAP_STEP];
      assign wd_last[gt] = tb_prev_q[WD_BASE + gt * TAP_STEP];
    end
  endgenerate

  logic fi_fire, wd_fire;

  tb_tap_select #(.N(NTAP)) u_fi_tap (
    .tap_now  (fi_now),
    .tap_last (fi_last),
    .code     (ctrl_q[CB_FI_PER +: CODE_W]),
    .fire     (fi_fire)
  );

  tb_tap_select #(.N(NTAP)) u_wd_tap (
    .tap_now  (wd_now),
    .tap_last (wd_last),
    .code     (ctrl_q[CB_WD_PER +: CODE_W]),
    .fire     (wd_fire)
  );

  // interval timer
  logic [DATA_W-1:0] pit_cnt;
  logic              pit_exp;

  pit_counter #(.W(DATA_W)) u_pit (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick        (tb_tick),
    .load_wr     (pit_wr),
    .load_val    (reg_wdata),
    .auto_reload (ctrl_q[CB_PIT_AR]),
    .count       (pit_cnt),
    .expire      (pit_exp)
  );

  // status register
  logic [DATA_W-1:0] stat_q, stat_d, stat_set, stat_clr;
  logic              stat_en;
  logic              wd_set_arm, wd_set_int, wd_load;

  wdt_stage_ctrl u_wdt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fire      (wd_fire),
    .st_armed  (stat_q[SB_WD_ARM]),
    .st_int    (stat_q[SB_WD_INT]),
    .kind      (ctrl_q[CB_WD_RST +: 2]),
    .set_armed (wd_set_arm),
    .set_int   (wd_set_int),
    .load_kind (wd_load),
    .req_core  (rst_req_core),
    .req_chip  (rst_req_chip),
    .req_sys   (rst_req_system)
  );

  always_comb begin
    stat_clr = stat_wr ? (reg_wdata & STAT_MASK) : '0;
    stat_set = '0;
    stat_set[SB_FI]     = fi_fire;
    stat_set[SB_PIT]    = pit_exp;
    stat_set[SB_WD_ARM] = wd_set_arm;
    stat_set[SB_WD_INT] = wd_set_int;
    stat_d = (stat_q & ~stat_clr) | stat_set;
    if (wd_load) stat_d[SB_RST +: 2] = ctrl_q[CB_WD_RST +: 2];
    stat_en = (|stat_clr) | (|stat_set) | wd_load;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  // read mux
  always_comb begin
    case (reg_addr_e'(reg_addr))
      ADDR_CTRL: reg_rdata = ctrl_q;
      ADDR_STAT: reg_rdata = stat_q;
      ADDR_PIT:  reg_rdata = pit_cnt;
      default:   reg_rdata = '0;
    endcase
  end

  // interrupts
  assign irq_fixed    = stat_q[SB_FI]     & ctrl_q[CB_FI_IE];
  assign irq_interval = stat_q[SB_PIT]    & ctrl_q[CB_PIT_IE];
  assign irq_watchdog = stat_q[SB_WD_INT] & ctrl_q[CB_WD_IE];

  initial begin
    if (FI_TOP >= TB_W || WD_TOP >= TB_W)
      $error("time-base tap outside TB_W");
  end

endmodule

// File: rtl/emb_timer_unit_chk.sv
module emb_timer_unit_chk #(
  parameter int TB_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr_en,
  input logic [1:0]      reg_addr,
  input logic [TB_W-1:0] tbase,
  input logic            irq_fixed,
  input logic            irq_watchdog,
  input logic            rst_req_core,
  input logic            rst_req_chip,
  input logic            rst_req_system,
  input logic [31:0]     stat_q,
  input logic [31:0]     pit_cnt
);

  logic [TB_W-1:0] seen_tb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_tb_q <= '0;
    else        seen_tb_q <= tbase;
  end

  AST_PIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_wr_en && reg_addr == 2'd2) && (tbase == seen_tb_q)) |=> $stable(pit_cnt)); // R6

  AST_FIT_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fixed |-> stat_q[26]); // R4

  AST_WDT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[30]) |-> $past(stat_q[31])); // R9

  AST_WDT_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_watchdog |-> stat_q[30]); // R9

  AST_RST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req_core, rst_req_chip, rst_req_system})); // R10

  AST_RST_CORE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_core |-> (stat_q[29:28] == 2'd1)); // R10

  AST_RST_CHIP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_chip |-> (stat_q[29:28] == 2'd2)); // R10

  AST_RST_SYS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_system |-> (stat_q[29:28] == 2'd3)); // R10

endmodule

bind emb_timer_unit emb_timer_unit_chk #(.TB_W(TB_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_wr_en      (reg_wr_en),
  .reg_addr       (reg_addr),
  .tbase          (tbase),
  .irq_fixed      (irq_fixed),
  .irq_watchdog   (irq_watchdog),
  .rst_req_core   (rst_req_core),
  .rst_req_chip   (rst_req_chip),
  .rst_req_system (rst_req_system),
  .stat_q         (stat_q),
  .pit_cnt        (pit_cnt)
);

// File: tb/emb_timer_unit_test.sv
module emb_timer_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [31:0] tbase = 32'd0;
  logic        irq_fixed, irq_interval, irq_watchdog;
  logic        rst_req_core, rst_req_chip, rst_req_system;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  emb_timer_unit uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr_en      (reg_wr_en),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .tbase          (tbase),
    .irq_fixed      (irq_fixed),
    .irq_interval   (irq_interval),
    .irq_watchdog   (irq_watchdog),
    .rst_req_core   (rst_req_core),
    .rst_req_chip   (rst_req_chip),
    .rst_req_system (rst_req_system)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    reg_wdata = 32'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic flip(input int b);
    tbase = tbase ^ (32'd1 << b);
    @(negedge clk);
  endtask

  logic [31:0] v;

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 32'd0);
    rd(2'd1, v); check("R1 stat", v, 32'd0);
    rd(2'd2, v); check("R1 count", v, 32'd0);
    check("R1 outputs", {26'd0, irq_fixed, irq_interval, irq_watchdog,
          rst_req_core, rst_req_chip, rst_req_system}, 32'd0);

    // R2 register map
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R2 ctrl bits", v, 32'hFFC0_0000);
    wr(2'd3, 32'h1234_5678);
    rd(2'd3, v); check("R2 addr3 read", v, 32'd0);
    rd(2'd0, v); check("R2 addr3 write ignored", v, 32'hFFC0_0000);
    wr(2'd0, 32'd0);
    rd(2'd0, v); check("R2 ctrl cleared", v, 32'd0);

    // R3 R4 R5 fixed-interval sweep
    for (int c = 0; c < 4; c++) begin
      for (int ie = 0; ie < 2; ie++) begin
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, (32'(c) << 24) | (32'(ie) << 23));
        flip(9 + 4 * ((c + 1) % 4));
        rd(2'd1, v); check("R3 other tap ignored", {31'd0, v[26]}, 32'd0);
        flip(9 + 4 * c);
        rd(2'd1, v); check("R3 selected tap sets", {31'd0, v[26]}, 32'd1);
        check("R4 irq_fixed gate", {31'd0, irq_fixed}, 32'(ie));
        wr(2'd1, 32'h0800_0000);
        rd(2'd1, v); check("R5 zero bit kept", {31'd0, v[26]}, 32'd1);
        wr(2'd1, 32'h0400_0000);
        rd(2'd1, v); check("R5 one bit cleared", {31'd0, v[26]}, 32'd0);
        check("R4 irq_fixed low", {31'd0, irq_fixed}, 32'd0);
      end
    end

    // R6 R7 interval timer sweep
    wr(2'd0, 32'd0);
    for (int n = 2; n <= 5; n++) begin
      for (int ar = 0; ar < 2; ar++) begin
        for (int ie = 0; ie < 2; ie++) begin
          wr(2'd1, 32'hFFFF_FFFF);
          wr(2'd0, (32'(ie) << 26) | (32'(ar) << 22));
          wr(2'd2, 32'(n));
          rd(2'd2, v); check("R6 load", v, 32'(n));
          @(negedge clk);
          rd(2'd2, v); check("R6 hold without tick", v, 32'(n));
          for (int k = 0; k < n - 1; k++) flip(0);
          rd(2'd2, v); check("R6 count before expiry", v, 32'd1);
          rd(2'd1, v); check("R6 no early expiry", {31'd0, v[27]}, 32'd0);
          flip(0);
          rd(2'd1, v); check("R6 expiry status", {31'd0, v[27]}, 32'd1);
          check("R6 irq_interval gate", {31'd0, irq_interval}, 32'(ie));
          rd(2'd2, v); check("R7 count after expiry", v, (ar != 0) ? 32'(n) : 32'd0);
          wr(2'd1, 32'h0800_0000);
          for (int k = 0; k < n; k++) flip(0);
          rd(2'd1, v); check("R7 second expiry", {31'd0, v[27]}, 32'(ar));
        end
      end
    end

    // R8 reload 0 and 1
    for (int r = 0; r < 2; r++) begin
      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd0, (32'd1 << 26) | (32'd1 << 22));
      wr(2'd2, 32'(r));
      for (int k = 0; k < 6; k++) flip(0);
      rd(2'd2, v); check("R8 count held", v, 32'(r));
      rd(2'd1, v); check("R8 no expiry", {31'd0, v[27]}, 32'd0);
      check("R8 no irq", {31'd0, irq_interval}, 32'd0);
    end

    // R9 R10 watchdog sweep
    for (int c = 0; c < 4; c++) begin
      for (int kd = 0; kd < 4; kd++) begin
        logic [31:0] exp_rst;
        exp_rst = (kd == 0) ? 32'd0 : (32'd1 << (kd - 1));
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, (32'(c) << 30) | (32'(kd) << 28) | (32'(kd % 2) << 27));
        flip(17 + 4 * ((c + 1) % 4));
        rd(2'd1, v); check("R9 other tap ignored", {28'd0, v[31:28]}, 32'h0);
        flip(17 + 4 * c);
        rd(2'd1, v); check("R9 first stage", {28'd0, v[31:28]}, 32'h8);
        check("R9 no irq at first stage", {31'd0, irq_watchdog}, 32'd0);
        flip(17 + 4 * c);
        rd(2'd1, v); check("R9 second stage", {28'd0, v[31:28]}, 32'hC);
        check("R9 irq_watchdog gate", {31'd0, irq_watchdog}, 32'(kd % 2));
        check("R10 no reset before third", {29'd0, rst_req_system, rst_req_chip, rst_req_core}, 32'd0);
        flip(17 + 4 * c);
        rd(2'd1, v); check("R10 kind copied", {28'd0, v[31:28]}, 32'hC | 32'(kd));
        check("R10 reset request", {29'd0, rst_req_system, rst_req_chip, rst_req_core}, exp_rst);
        @(negedge clk);
        check("R10 single-cycle request", {29'd0, rst_req_system, rst_req_chip, rst_req_core}, 32'd0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule